// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Registers

This unit performs 32-by-32 multiplication and division, signed or unsigned, and keeps the results in two 32-bit result registers, HI and LO. A multiply leaves the 64-bit product split across the pair. A divide leaves the quotient in LO and the remainder in HI. Each operation starts a busy countdown that models result latency. For a multiply the countdown length depends on the magnitude of the first operand. For a divide it is fixed, and the division itself runs as a bit-serial restoring loop inside that window.

A requester reads HI or LO by raising a read request. While the countdown is running, the unit answers with a stall. In the first cycle the countdown is clear, it returns the value. HI and LO can also be loaded directly from the first operand. A new operation started while the unit is busy replaces the one in flight and reloads the countdown.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO are zero and `busy` is low. A read request in that state returns 0 with `rd_valid` high and `stall` low.
- R2: The `op_kind` encoding is 0 for a signed multiply, 1 for an unsigned multiply, 2 for a signed divide and 3 for an unsigned divide. A signed multiply writes the 64-bit two's-complement product of `opa` and `opb`, with the upper word in HI and the lower word in LO.
- R3: An unsigned multiply writes the 64-bit unsigned product, with the upper word in HI and the lower word in LO.
- R4: The busy window of a multiply is determined in three steps.
  - First take a value v. For an unsigned multiply, v is `opa | 1`. For a signed multiply, v is `(opa ^ (opa >>> 21)) | 1`, where `>>>` is an arithmetic shift.
  - Count the leading zeros of v; call that count z.
  - The window lasts 15 cycles when z is 0 to 10, 11 cycles when z is 11 to 21, and 7 cycles when z is 22 to 31.
- R5: A divide keeps the unit busy for 37 cycles. It writes the quotient, truncated toward zero, to LO. It writes the remainder to HI; the remainder takes the sign of the dividend.
- R6: A signed divide of 0x80000000 by 0xFFFFFFFF yields LO = 0x80000000 and HI = 0 without fault.
- R7: For division by zero:
  - A signed divide gives HI = `opa`, with LO = 1 when `opa` is negative and LO = 0xFFFFFFFF otherwise.
  - An unsigned divide gives LO = 0xFFFFFFFF and HI = `opa`.
- R8: While `rd_req` is high and the countdown is running, `stall` is high and `rd_valid` is low. A request issued in the cycle right after a start stalls for exactly the busy window of that operation. Once the countdown is clear, `rd_valid` is high and `rd_data` carries HI when `rd_sel` = 1 and LO when `rd_sel` = 0, in the same cycle.
- R9: `hi_wr` loads HI from `opa` and `lo_wr` loads LO from `opa`. The new value is readable in the next cycle without a stall.
- R10: A start while busy reloads the countdown for the new operation. The earlier operation's results never reach HI or LO.
- R11: With no start and no write, HI and LO hold their values indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start the operation selected by `op_kind` |
| op_kind | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opa | input | 32 | First operand (multiplicand, dividend, HI/LO write data) |
| opb | input | 32 | Second operand (multiplier, divisor) |
| hi_wr | input | 1 | Load HI from `opa` |
| lo_wr | input | 1 | Load LO from `opa` |
| rd_req | input | 1 | Read request for HI or LO |
| rd_sel | input | 1 | Read select: 1 HI, 0 LO |
| rd_data | output | 32 | Selected register value, meaningful when `rd_valid` |
| rd_valid | output | 1 | Read request answered this cycle |
| stall | output | 1 | Read request held off by the busy countdown |
| busy | output | 1 | Countdown running |

## Verification
The multiply patterns pair small, mid-range and full-width first operands. That separates the three latency bands, and it includes signed values whose upper bits are all ones, which must land in the short band despite their large unsigned magnitude. The divide patterns mix sign combinations of dividend and divisor to tell truncation toward zero apart from floor division. The most negative dividend over minus one and the zero divisors show that the serial divider's natural outcome, after sign fix-up, matches the defined results. Directed cases cover the direct HI/LO loads, a restart in the middle of a divide that must suppress the stale quotient, and idle hold.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int DIV_CYCLES = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4,
  parameter int LZ_BAND    = 11,
  parameter int SIGN_SHIFT = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_start,
  input  logic [1:0]  op_kind,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic        hi_wr,
  input  logic        lo_wr,
  input  logic        rd_req,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        stall,
  output logic        busy
);

  localparam int MUL_MAX   = MUL_BASE + 2 * MUL_STEP;
  localparam int LAT_MAX   = (DIV_CYCLES > MUL_MAX) ? DIV_CYCLES : MUL_MAX;
  localparam int CW        = $clog2(LAT_MAX + 1);
  localparam int DIV_STEPS = 32;
  localparam int SW        = $clog2(DIV_STEPS + 1);

  function automatic logic [5:0] clz32(input logic [31:0] v);
    logic found;
    clz32 = 6'd0;
    found = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else      clz32 = clz32 + 6'd1;
      end
    end
  endfunction

  logic [31:0]   hi_q, lo_q;
  logic [CW-1:0] cnt;
  logic          div_active;
  logic [SW-1:0] step;
  logic [31:0]   rem_q, quo_q, dsr_q;
  logic          negq_q, negr_q;

  wire is_div    = op_kind[1];
  wire is_signed = ~op_kind[0];

  wire [31:0] sgn_mix = opa ^ 32'($signed(opa) >>> SIGN_SHIFT);
  wire [31:0] mul_src = (is_signed ? sgn_mix : opa) | 32'd1;
  wire [5:0]  lz      = clz32(mul_src);

  logic [CW-1:0] start_lat;
  always_comb begin
    int band;
    band = int'(lz) / LZ_BAND;
    if (band > 2) band = 2;
    if (is_div) start_lat = CW'(DIV_CYCLES);
    else        start_lat = CW'(MUL_BASE + (2 - band) * MUL_STEP);
  end

  wire [63:0] ext_a   = {{32{is_signed & opa[31]}}, opa};
  wire [63:0] ext_b   = {{32{is_signed & opb[31]}}, opb};
  wire [63:0] product = ext_a * ext_b;

  wire [31:0] abs_a = (is_signed & opa[31]) ? -opa : opa;
  wire [31:0] abs_b = (is_signed & opb[31]) ? -opb : opb;

  wire [32:0] rem_sh = {rem_q, quo_q[31]};
  wire [33:0] diff   = {1'b0, rem_sh} - {2'b00, dsr_q};
  wire        take   = ~diff[33];
  wire [31:0] rem_nx = take ? diff[31:0] : rem_sh[31:0];
  wire [31:0] quo_nx = {quo_q[30:0], take};
  wire [31:0] q_fin  = negq_q ? -quo_nx : quo_nx;
  wire [31:0] r_fin  = negr_q ? -rem_nx : rem_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= '0;
      lo_q       <= '0;
      cnt        <= '0;
      div_active <= 1'b0;
      step       <= '0;
      rem_q      <= '0;
      quo_q      <= '0;
      dsr_q      <= '0;
      negq_q     <= 1'b0;
      negr_q     <= 1'b0;
    end else if (op_start) begin
      cnt <= start_lat;
      if (is_div) begin
        div_active <= 1'b1;
        step       <= SW'(DIV_STEPS);
        rem_q      <= '0;
        quo_q      <= abs_a;
        dsr_q      <= abs_b;
        negq_q     <= is_signed & (opa[31] ^ opb[31]);
        negr_q     <= is_signed & opa[31];
      end else begin
        div_active <= 1'b0;
        hi_q       <= product[63:32];
        lo_q       <= product[31:0];
      end
    end else begin
      if (cnt != '0) cnt <= cnt - CW'(1);
      if (hi_wr) hi_q <= opa;
      if (lo_wr) lo_q <= opa;
      if (div_active) begin
        step  <= step - SW'(1);
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        if (step == SW'(1)) begin
          div_active <= 1'b0;
          hi_q       <= r_fin;
          lo_q       <= q_fin;
        end
      end
    end
  end

  assign busy     = (cnt != '0);
  assign stall    = rd_req & busy;
  assign rd_valid = rd_req & ~busy;
  assign rd_data  = rd_sel ? hi_q : lo_q;

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy);

  assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_start) |=> (cnt == $past(cnt) - CW'(1)));

  assert_div_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_active |-> busy);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !op_start && !hi_wr && !lo_wr) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // kind, a, b, exp_hi, exp_lo, exp_lat
  localparam logic [135:0] VEC [NV] = '{
    {2'd0, 32'h00000003, 32'hFFFFFFFB, 32'hFFFFFFFF, 32'hFFFFFFF1, 6'd7},
    {2'd0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000, 6'd15},
    {2'd0, 32'h000FFFFF, 32'h00000002, 32'h00000000, 32'h001FFFFE, 6'd11},
    {2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 6'd7},
    {2'd0, 32'h00400000, 32'h00000004, 32'h00000000, 32'h01000000, 6'd15},
    {2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001, 6'd15},
    {2'd1, 32'h00100000, 32'h00000010, 32'h00000000, 32'h01000000, 6'd11},
    {2'd2, 32'd100,      32'd7,        32'd2,        32'd14,       6'd37},
    {2'd2, 32'hFFFFFF9C, 32'd7,        32'hFFFFFFFE, 32'hFFFFFFF2, 6'd37},
    {2'd2, 32'd100,      32'hFFFFFFF9, 32'd2,        32'hFFFFFFF2, 6'd37},
    {2'd3, 32'hFFFFFFFF, 32'h00000010, 32'h0000000F, 32'h0FFFFFFF, 6'd37},
    {2'd2, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 6'd37},
    {2'd2, 32'hFFFFFFFB, 32'd0,        32'hFFFFFFFB, 32'h00000001, 6'd37},
    {2'd3, 32'd7,        32'd0,        32'd7,        32'hFFFFFFFF, 6'd37}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_start = 1'b0, hi_wr = 1'b0, lo_wr = 1'b0, rd_req = 1'b0, rd_sel = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] rd_data;
  logic rd_valid, stall, busy;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_hilo dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .opa(opa), .opb(opb), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data),
    .rd_valid(rd_valid), .stall(stall), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic [1:0] k, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_kind = k; opa = a; opb = b; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic wait_read(output int n);
    rd_req = 1'b1; rd_sel = 1'b0;
    #1;
    n = 0;
    while (stall && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_req = 1'b1; rd_sel = 1'b0; #1;
    check("R1 lo", rd_data, 32'd0);
    check("R1 valid", {31'd0, rd_valid}, 32'd1);
    check("R1 busy", {31'd0, busy}, 32'd0);
    rd_sel = 1'b1; #1;
    check("R1 hi", rd_data, 32'd0);
    rd_req = 1'b0; #1;
    check("R8 no request no valid", {31'd0, rd_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag, ltag;
      logic [1:0] k;
      k = VEC[i][135:134];
      tag  = (k == 2'd0) ? "R2" : (k == 2'd1) ? "R3" : (i == 11) ? "R6" : (i >= 12) ? "R7" : "R5";
      ltag = k[1] ? "R5 latency" : "R4 latency";
      start_op(k, VEC[i][133:102], VEC[i][101:70]);
      wait_read(n);
      check({ltag, " (R8 stall count)"}, n, {26'd0, VEC[i][5:0]});
      check("R8 valid after stall", {31'd0, rd_valid}, 32'd1);
      check({tag, " lo"}, rd_data, VEC[i][37:6]);
      rd_sel = 1'b1; #1;
      check({tag, " hi"}, rd_data, VEC[i][69:38]);
      rd_req = 1'b0;
    end

    // R9 direct writes
    @(negedge clk);
    opa = 32'hCAFE0001; hi_wr = 1'b1;
    @(negedge clk);
    hi_wr = 1'b0; opa = 32'h0BAD0002; lo_wr = 1'b1;
    @(negedge clk);
    lo_wr = 1'b0;
    rd_req = 1'b1; rd_sel = 1'b1; #1;
    check("R9 hi no stall", {31'd0, stall}, 32'd0);
    check("R9 hi", rd_data, 32'hCAFE0001);
    rd_sel = 1'b0; #1;
    check("R9 lo", rd_data, 32'h0BAD0002);
    rd_req = 1'b0;

    // R10 restart mid-divide with unsigned multiply of 1 by 9 (7 cycles)
    start_op(2'd2, 32'd1000, 32'd3);
    repeat (4) @(negedge clk);
    start_op(2'd1, 32'd1, 32'd9);
    wait_read(n);
    check("R10 restart latency", n, 32'd7);
    check("R10 lo", rd_data, 32'd9);
    rd_sel = 1'b1; #1;
    check("R10 hi", rd_data, 32'd0);
    rd_req = 1'b0;
    repeat (40) @(negedge clk);
    rd_req = 1'b1; rd_sel = 1'b0; #1;
    check("R10 stale quotient discarded", rd_data, 32'd9);
    // R11 idle hold
    rd_req = 1'b0;
    repeat (10) @(negedge clk);
    rd_req = 1'b1; rd_sel = 1'b1; #1;
    check("R11 hi held", rd_data, 32'd0);
    rd_sel = 1'b0; #1;
    check("R11 lo held", rd_data, 32'd9);
    rd_req = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule